// File: doc/BRIEF.md
# MSI Termination and Interrupt Coalescer

This block ends posted message-signalled interrupt writes. Each write carries a byte address and a data word. The address picks one of 16 groups and one of 8 index registers inside that group. The data value, 0 to 15, picks one bit inside that register. The bit is then held as pending. This gives 2048 distinct vectors. They are folded onto 16 level interrupt lines, one per group.

Software serves an interrupt in three steps:

1. It sees a group line high.
2. It reads that group's summary register to learn which index registers hold work.
3. It reads those index registers. A read returns the pending bits and clears them in the same step.

Software steers a vector to a given line by choosing the address the vector writes to. The block applies no policy of its own.

Top module: `msi_coalescer`

## Requirements
- R1: A write with `wr_addr = (g << 19) | (x << 16)` (g in 0..15, x in 0..7) and `wr_data` in 0..15 sets bit `wr_data` of index register (g, x). A later read of that address shows the bit in `rd_data[15:0]`.
- R2: A read of an index register returns its 16 pending bits in `rd_data[15:0]`, with `rd_data[31:16]` zero. The same read clears all 16 bits, so an immediate second read returns zero.
- R3: A read of `0x800000 | (g << 16)` returns the summary of group g. Bit x of `rd_data[7:0]` is 1 exactly when index register (g, x) is non-zero, and `rd_data[31:8]` is zero. A summary read changes no state, so repeating it returns the same value.
- R4: `irq_o[g]` is high exactly while some index register of group g is non-zero. It rises on the clock edge that registers an accepted write.
- R5: A write that hits an index register in the same cycle as a clearing read of that register is kept. The read returns the bits from before the write, and the new bit stays pending.
- R6: A write whose data exceeds 15 changes nothing.
- R7: A write or read whose address is outside both windows is ignored, and such a read returns zero. This covers any address with a non-zero `addr[15:0]`, and any address at or above 0x800000 with a non-zero `addr[22:20]`.
- R8: A write to a summary address changes nothing.
- R9: A write to a bit that is already pending leaves the register unchanged and raises no error.
- R10: `rd_ack` is high in the cycle after each `rd_valid`, with `rd_data` valid in that cycle. Out of reset, all pending bits, `irq_o` and `rd_ack` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Posted interrupt write strobe |
| wr_addr | input | 24 | Write byte offset |
| wr_data | input | 32 | Write data; the vector bit number |
| rd_valid | input | 1 | Register read request |
| rd_addr | input | 24 | Read byte offset |
| rd_ack | output | 1 | Read data valid, one cycle after request |
| rd_data | output | 32 | Read data |
| irq_o | output | 16 | Level interrupt per group |

## Verification
The assertions take the following for granted about the inputs:
- `wr_addr` and `rd_addr` hold known values whenever their strobe is high.
- Reads and writes may arrive in the same cycle.

The rise check on `irq_o` depends on one fact: a clearing read can only erase bits that were already present, never the bit an accepted write sets in that cycle.

The stimulus keeps all strobes and addresses fully driven on every cycle. It aims most random traffic at a few groups, so that merges and collisions between reads and writes happen often. A small share of addresses and data values is placed outside the legal ranges.

// File: rtl/msi_coalescer_pkg.sv
package msi_coalescer_pkg;
    localparam int unsigned GRPS      = 16;
    localparam int unsigned IDXS      = 8;
    localparam int unsigned BITS      = 16;
    localparam int unsigned DW        = 32;
    localparam int unsigned GW        = $clog2(GRPS);
    localparam int unsigned XW        = $clog2(IDXS);
    localparam int unsigned BW        = $clog2(BITS);
    localparam int unsigned REG_SHIFT = 16;
    localparam int unsigned GRP_SHIFT = REG_SHIFT + XW;
    localparam int unsigned SUM_BIT   = GRP_SHIFT + GW;
    localparam int unsigned AW        = SUM_BIT + 1;

    typedef struct packed {
        logic          idx_hit;
        logic          sum_hit;
        logic [GW-1:0] grp;
        logic [XW-1:0] idx;
    } dec_t;

    typedef logic [GRPS-1:0][IDXS-1:0][BITS-1:0] pend_t;
    typedef logic [GRPS-1:0][IDXS-1:0]           summ_t;
endpackage

// File: rtl/msi_addr_decode.sv
module msi_addr_decode
    import msi_coalescer_pkg::*;
(
    input  logic [AW-1:0] addr,
    output dec_t          dec
);
    logic low_ok;

    always_comb begin
        dec    = '0;
        low_ok = (addr[REG_SHIFT-1:0] == '0);
        if (!addr[SUM_BIT]) begin
            dec.idx_hit = low_ok;
            dec.grp     = addr[SUM_BIT-1:GRP_SHIFT];
            dec.idx     = addr[GRP_SHIFT-1:REG_SHIFT];
        end else begin
            dec.sum_hit = low_ok && (addr[SUM_BIT-1:REG_SHIFT+GW] == '0);
            dec.grp     = addr[REG_SHIFT+GW-1:REG_SHIFT];
        end
    end
endmodule

// File: rtl/msi_pend_array.sv
module msi_pend_array
    import msi_coalescer_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [GW-1:0] set_grp,
    input  logic [XW-1:0] set_idx,
    input  logic [BW-1:0] set_bit,
    input  logic          clr_en,
    input  logic [GW-1:0] clr_grp,
    input  logic [XW-1:0] clr_idx,
    output pend_t         pend_o
);
    pend_t pend_d, pend_q;

    // Clear first, then set: a write colliding with a clearing read survives.
    always_comb begin
        pend_d = pend_q;
        if (clr_en) begin
            pend_d[clr_grp][clr_idx] = '0;
        end
        if (set_en) begin
            pend_d[set_grp][set_idx][set_bit] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/msi_summary.sv
module msi_summary
    import msi_coalescer_pkg::*;
(
    input  pend_t           pend_i,
    output summ_t           summ_o,
    output logic [GRPS-1:0] irq_o
);
    for (genvar g = 0; g < GRPS; g++) begin : g_grp
        for (genvar x = 0; x < IDXS; x++) begin : g_idx
            assign summ_o[g][x] = |pend_i[g][x];
        end
        assign irq_o[g] = |summ_o[g];
    end
endmodule

// File: rtl/msi_coalescer.sv
module msi_coalescer
    import msi_coalescer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              rd_valid,
    input  logic [AW-1:0]     rd_addr,
    output logic              rd_ack,
    output logic [DW-1:0]     rd_data,
    output logic [GRPS-1:0]   irq_o
);
    typedef struct packed {
        logic          ack;
        logic [DW-1:0] data;
    } rd_state_t;

    dec_t      wdec, rdec;
    pend_t     pend;
    summ_t     summ;
    logic      set_en, clr_en;
    rd_state_t st_d, st_q;

    msi_addr_decode i_wdec (.addr(wr_addr), .dec(wdec));
    msi_addr_decode i_rdec (.addr(rd_addr), .dec(rdec));

    assign set_en = wr_valid && wdec.idx_hit && (wr_data < DW'(BITS));
    assign clr_en = rd_valid && rdec.idx_hit;

    msi_pend_array i_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (set_en),
        .set_grp(wdec.grp),
        .set_idx(wdec.idx),
        .set_bit(wr_data[BW-1:0]),
        .clr_en (clr_en),
        .clr_grp(rdec.grp),
        .clr_idx(rdec.idx),
        .pend_o (pend)
    );

    msi_summary i_summ (
        .pend_i(pend),
        .summ_o(summ),
        .irq_o (irq_o)
    );

    always_comb begin
        st_d      = '0;
        st_d.ack  = rd_valid;
        if (rd_valid) begin
            if (rdec.idx_hit) begin
                st_d.data[BITS-1:0] = pend[rdec.grp][rdec.idx];
            end else if (rdec.sum_hit) begin
                st_d.data[IDXS-1:0] = summ[rdec.grp];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_ack  = st_q.ack;
    assign rd_data = st_q.data;
endmodule

// File: rtl/msi_coalescer_chk.sv
module msi_coalescer_chk
    import msi_coalescer_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            wr_valid,
    input logic [AW-1:0]   wr_addr,
    input logic [DW-1:0]   wr_data,
    input logic            rd_valid,
    input logic [AW-1:0]   rd_addr,
    input logic            rd_ack,
    input logic [DW-1:0]   rd_data,
    input logic [GRPS-1:0] irq_o
);
    // R10
    ack_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> rd_ack);

    // R10
    no_spur_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> !rd_ack);

    // R4
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_addr[SUM_BIT] && wr_addr[REG_SHIFT-1:0] == '0 && wr_data < DW'(BITS))
        |=> irq_o[$past(wr_addr[SUM_BIT-1:GRP_SHIFT])]);

    // R2
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(irq_o) & ~irq_o)) |-> $past(rd_valid));

    // R2
    idx_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_addr[SUM_BIT]) |=> rd_data[DW-1:BITS] == '0);

    // R3
    sum_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_addr[SUM_BIT]) |=> rd_data[DW-1:IDXS] == '0);

    // R7
    bad_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_addr[REG_SHIFT-1:0] != '0) |=> rd_data == '0);
endmodule

bind msi_coalescer msi_coalescer_chk i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_valid(wr_valid),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_valid(rd_valid),
    .rd_addr (rd_addr),
    .rd_ack  (rd_ack),
    .rd_data (rd_data),
    .irq_o   (irq_o)
);

// File: tb/test_msi_coalescer.sv
module test_msi_coalescer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [23:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_valid = 1'b0;
    logic [23:0] rd_addr = '0;
    logic        rd_ack;
    logic [31:0] rd_data;
    logic [15:0] irq_o;

    int total = 0;
    int bad = 0;
    logic [15:0] mdl [16][8];

    always #10 clk = ~clk;

    msi_coalescer i_msi_coalescer (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_addr(rd_addr),
        .rd_ack(rd_ack), .rd_data(rd_data), .irq_o(irq_o)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic is_idx(input logic [23:0] a);
        return (a < 24'h800000) && (a[15:0] == 16'h0);
    endfunction

    function automatic logic is_sum(input logic [23:0] a);
        return (a >= 24'h800000) && (a <= 24'h8F0000) && (a[15:0] == 16'h0);
    endfunction

    function automatic logic [31:0] mdl_read(input logic [23:0] a);
        logic [31:0] r = '0;
        if (is_idx(a)) begin
            r[15:0] = mdl[a / 24'h80000][(a / 24'h10000) % 8];
        end else if (is_sum(a)) begin
            for (int x = 0; x < 8; x++) r[x] = (mdl[(a - 24'h800000) / 24'h10000][x] != 0);
        end
        return r;
    endfunction

    function automatic logic [15:0] mdl_irq();
        logic [15:0] q = '0;
        for (int g = 0; g < 16; g++)
            for (int x = 0; x < 8; x++)
                if (mdl[g][x] != 0) q[g] = 1'b1;
        return q;
    endfunction

    function automatic logic [23:0] ia(input int g, input int x);
        return 24'(g * 24'h80000 + x * 24'h10000);
    endfunction

    task automatic op(input logic wv, input logic [23:0] wa, input logic [31:0] wd,
                      input logic rv, input logic [23:0] ra, input string req);
        logic [31:0] exp_rd;
        @(negedge clk);
        wr_valid = wv; wr_addr = wa; wr_data = wd;
        rd_valid = rv; rd_addr = ra;
        exp_rd = mdl_read(ra);
        @(negedge clk);
        wr_valid = 1'b0; rd_valid = 1'b0;
        if (rv && is_idx(ra)) mdl[ra / 24'h80000][(ra / 24'h10000) % 8] = '0;
        if (wv && is_idx(wa) && wd < 16) mdl[wa / 24'h80000][(wa / 24'h10000) % 8][wd[3:0]] = 1'b1;
        chk(rd_ack == rv, {req, " R10 ack"}, 32'(rd_ack), 32'(rv));
        if (rv) chk(rd_data == exp_rd, {req, " rd_data"}, rd_data, exp_rd);
        chk(irq_o == mdl_irq(), {req, " R4 irq"}, 32'(irq_o), 32'(mdl_irq()));
    endtask

    task automatic wr(input logic [23:0] a, input logic [31:0] d, input string req);
        op(1'b1, a, d, 1'b0, '0, req);
    endtask

    task automatic rd(input logic [23:0] a, input string req);
        op(1'b0, '0, '0, 1'b1, a, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=%h exp=%h", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed;
        for (int g = 0; g < 16; g++) for (int x = 0; x < 8; x++) mdl[g][x] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(irq_o == 0, "R10 reset irq", 32'(irq_o), 0);
        chk(rd_ack == 0, "R10 reset ack", 32'(rd_ack), 0);

        // R1 set bit 9 of (3,5)
        wr(ia(3, 5), 9, "R1");
        rd(ia(3, 5), "R1 readback");
        // R2 second read sees cleared register
        rd(ia(3, 5), "R2 clear");
        // R3 summary shows two index registers, repeat read unchanged
        wr(ia(3, 1), 0, "R3 setup");
        wr(ia(3, 6), 15, "R3 setup");
        rd(24'h830000, "R3 summary");
        rd(24'h830000, "R3 summary repeat");
        // R9 duplicate write merges
        wr(ia(3, 1), 0, "R9 dup");
        wr(ia(3, 1), 4, "R9 second");
        rd(ia(3, 1), "R9 merged");
        rd(ia(3, 6), "R4 drain");
        // R6 data over 15 dropped
        wr(ia(7, 2), 16, "R6");
        wr(ia(7, 2), 32'hFFFF_FFFF, "R6");
        rd(ia(7, 2), "R6 empty");
        // R7 out-of-window addresses dropped, read as zero
        wr(24'h030004, 2, "R7 low bits");
        wr(24'h900000, 2, "R7 above summary");
        rd(24'h000000, "R7 check");
        rd(24'h900000, "R7 read zero");
        rd(24'h000100, "R7 read zero low");
        // R8 write to summary ignored
        wr(24'h850000, 3, "R8");
        rd(24'h850000, "R8 summary");
        // R5 collision of write and clearing read
        wr(ia(12, 4), 1, "R5 setup");
        op(1'b1, ia(12, 4), 7, 1'b1, ia(12, 4), "R5 collide");
        rd(ia(12, 4), "R5 survivor");
        // R4 group 15 line
        wr(ia(15, 7), 15, "R4 top");
        rd(24'h8F0000, "R3 top summary");
        rd(ia(15, 7), "R4 top clear");

        seed = 7;
        void'($urandom(seed));
        for (int n = 0; n < 1500; n++) begin
            logic [23:0] wa, ra;
            logic [31:0] wd;
            int k = $urandom % 16;
            wa = ia($urandom % 3, $urandom % 8);
            ra = (k < 4) ? 24'(24'h800000 + ($urandom % 3) * 24'h10000) : ia($urandom % 3, $urandom % 8);
            wd = ($urandom % 10 == 0) ? 32'($urandom % 64) : 32'($urandom % 16);
            if (k == 15) wa = 24'($urandom);
            if (k == 14) ra = 24'($urandom);
            op($urandom % 4 != 0, wa, wd, $urandom % 2 == 0, ra, "R1 R5 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule